// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address stream for a four-beat burst into a synchronous memory. An external address is captured together with its chip-select inputs on a rising clock edge when one of two active-low load strobes is low. One strobe belongs to the processor side and the other to the memory controller. From then on, only the low address bits change. They are stepped by an internal beat counter each time the active-low advance input is low. The upper address bits stay exactly as loaded.

The stepping order is chosen by a mode input. It is either interleaved, where the low bits equal the start value XOR the beat count, or linear, where the low bits count upward modulo the burst length from the start value. The block registers a chip-select result at every load and shows it on an output. A burst-active flag marks the beats of the current burst. A third output shows which strobe performed the most recent load.

Top module: `bseq_addr_gen`

## Requirements
- R1: While `rst_n` is low, all registered outputs are zero: `addr_out`, `burst_active`, `chip_sel` and `proc_started`.
- R2: When `ctrl_stb_n` is low at a rising edge, `addr_out` equals `addr_in` after that edge, regardless of the chip-select inputs.
- R3: When `proc_stb_n` is low, `ce_main_n` is high and `ctrl_stb_n` is high, that edge does not load. All outputs hold, apart from an ordinary advance step.
- R4: After a load, `proc_started` is 1 if the load came from the processor strobe and 0 if it came from the controller strobe. If both strobes are valid in the same cycle, the processor strobe wins.
- R5: A load overrides an advance in the same cycle. The beat count restarts at zero and `addr_out` equals the new address.
- R6: An advance step changes only the lowest BW bits of `addr_out`. Bits above them stay as loaded.
- R7: With `lin_mode` = 0 (interleaved), the low bits after the k-th advance since the load equal start XOR (k mod 4).
- R8: With `lin_mode` = 1 (linear), the low bits after the k-th advance since the load equal (start + k) mod 4.
- R9: While `adv_n` is high and no load occurs, `addr_out` holds its value (wait state).
- R10: The fourth advance after a load wraps the low bits back to the start value and clears `burst_active`. Further advances continue the cycle with `burst_active` staying 0.
- R11: `chip_sel` is 1 after a load only when `ce_main_n` is low and every auxiliary enable is at its active level (`ce_aux[i]` active high where bit i of AUX_ACT_HI is 1, active low otherwise). `burst_active` is set by a load only when `chip_sel` is set. While `chip_sel` is 0, advance has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_stb_n | input | 1 | Processor-side load strobe, active low, gated by `ce_main_n` |
| ctrl_stb_n | input | 1 | Controller-side load strobe, active low, always effective |
| adv_n | input | 1 | Burst advance, active low |
| lin_mode | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_in | input | AW | Address captured on a load |
| ce_main_n | input | 1 | Main chip enable, active low |
| ce_aux | input | NAUX | Auxiliary enables, polarity per AUX_ACT_HI |
| addr_out | output | AW | Registered burst address |
| burst_active | output | 1 | High during the beats of a selected burst |
| chip_sel | output | 1 | Registered chip-select result of the last load |
| proc_started | output | 1 | Last load came from the processor strobe |

## Verification
The bench builds the block with AW = 8, BW = 2, NAUX = 2 and mixed auxiliary polarities (one enable active high, one active low). The short address keeps the upper bits fully visible when R6 is checked. The mixed polarities let both decode paths of R11 be driven to select and to deselect. The bench walks all four start values through more than one full wrap in both orders. It also places wait states, same-cycle load-and-advance, and both strobes together at chosen beats. A behavioural model compares every output on every clock.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

   typedef enum logic {
      SRC_CTRL = 1'b0,
      SRC_PROC = 1'b1
   } load_src_e;

   function automatic int unsigned beats_of(input int unsigned bw);
      return 32'd1 << bw;
   endfunction

endpackage

// File: rtl/bseq_load_ctl.sv
module bseq_load_ctl
   import bseq_pkg::*;
#(
   parameter int unsigned NAUX       = 2,
   parameter logic [NAUX-1:0] AUX_ACT_HI = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            proc_stb_n,
   input  logic            ctrl_stb_n,
   input  logic            ce_main_n,
   input  logic [NAUX-1:0] ce_aux,
   output logic            load,
   output logic            sel_now,
   output logic            sel_q,
   output logic            by_proc_q
);

   logic [NAUX-1:0] aux_hit;
   logic            proc_v;
   logic            ctrl_v;
   load_src_e       src;

   generate
      if (NAUX < 1) begin : g_bad_naux
         $error("bseq_load_ctl: NAUX must be at least 1");
      end
      for (genvar gi = 0; gi < NAUX; gi++) begin : g_aux
         if (AUX_ACT_HI[gi]) begin : g_hi
            assign aux_hit[gi] = ce_aux[gi];
         end else begin : g_lo
            assign aux_hit[gi] = ~ce_aux[gi];
         end
      end
   endgenerate

   assign proc_v  = ~proc_stb_n & ~ce_main_n;
   assign ctrl_v  = ~ctrl_stb_n;
   assign load    = proc_v | ctrl_v;
   assign sel_now = ~ce_main_n & (&aux_hit);
   assign src     = proc_v ? SRC_PROC : SRC_CTRL;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         by_proc_q <= 1'b0;
      end else if (load) begin
         sel_q     <= sel_now;
         by_proc_q <= (src == SRC_PROC);
      end
   end

   // R4
   proc_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n && !ce_main_n && !ctrl_stb_n) |=> by_proc_q);

   // R3
   proc_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_stb_n && ce_main_n && ctrl_stb_n) |=> ($stable(sel_q) && $stable(by_proc_q)));

endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt #(
   parameter int unsigned BW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          sel_now,
   input  logic          step,
   output logic [BW-1:0] cnt_q,
   output logic [BW-1:0] cnt_nxt,
   output logic          active_q
);

   logic wrap;

   generate
      if (BW < 1) begin : g_bad_bw
         $error("bseq_beat_cnt: BW must be at least 1");
      end
   endgenerate

   assign wrap    = &cnt_q;
   assign cnt_nxt = cnt_q + {{(BW-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load) begin
         cnt_q    <= '0;
         active_q <= sel_now;
      end else if (step) begin
         cnt_q <= cnt_nxt;
         if (wrap) active_q <= 1'b0;
      end
   end

   // R10
   wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && wrap) |=> (!active_q && cnt_q == '0));

   // R5
   load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == '0));

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
   parameter int unsigned BW         = 2,
   parameter bit          HAS_LINEAR = 1'b1
) (
   input  logic [BW-1:0] start,
   input  logic [BW-1:0] cnt,
   input  logic          lin_mode,
   output logic [BW-1:0] low
);

   logic [BW-1:0] ilv;

   assign ilv = start ^ cnt;

   generate
      if (HAS_LINEAR) begin : g_both
         logic [BW-1:0] lin;
         assign lin = start + cnt;
         assign low = lin_mode ? lin : ilv;
      end else begin : g_ilv_only
         logic unused_mode;
         assign unused_mode = lin_mode;
         assign low = ilv;
      end
   endgenerate

endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
   import bseq_pkg::*;
#(
   parameter int unsigned AW         = 18,
   parameter int unsigned BW         = 2,
   parameter int unsigned NAUX       = 2,
   parameter logic [NAUX-1:0] AUX_ACT_HI = 2'b01,
   parameter bit          HAS_LINEAR = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            proc_stb_n,
   input  logic            ctrl_stb_n,
   input  logic            adv_n,
   input  logic            lin_mode,
   input  logic [AW-1:0]   addr_in,
   input  logic            ce_main_n,
   input  logic [NAUX-1:0] ce_aux,
   output logic [AW-1:0]   addr_out,
   output logic            burst_active,
   output logic            chip_sel,
   output logic            proc_started
);

   localparam int unsigned BEATS = beats_of(BW);
   localparam int unsigned UW    = AW - BW;

   logic          load;
   logic          sel_now;
   logic          step;
   logic [BW-1:0] cnt_q;
   logic [BW-1:0] cnt_nxt;
   logic [BW-1:0] start_q;
   logic [BW-1:0] low_nxt;
   logic [AW-1:0] addr_q;

   generate
      if (AW <= BW) begin : g_bad_aw
         $error("bseq_addr_gen: AW must exceed BW");
      end
      if (BEATS < 2) begin : g_bad_beats
         $error("bseq_addr_gen: burst must have at least two beats");
      end
   endgenerate

   bseq_load_ctl #(.NAUX(NAUX), .AUX_ACT_HI(AUX_ACT_HI)) u_load (
      .clk        (clk),
      .rst_n      (rst_n),
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .ce_main_n  (ce_main_n),
      .ce_aux     (ce_aux),
      .load       (load),
      .sel_now    (sel_now),
      .sel_q      (chip_sel),
      .by_proc_q  (proc_started)
   );

   assign step = ~adv_n & chip_sel & ~load;

   bseq_beat_cnt #(.BW(BW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .sel_now  (sel_now),
      .step     (step),
      .cnt_q    (cnt_q),
      .cnt_nxt  (cnt_nxt),
      .active_q (burst_active)
   );

   bseq_order #(.BW(BW), .HAS_LINEAR(HAS_LINEAR)) u_ord (
      .start    (start_q),
      .cnt      (cnt_nxt),
      .lin_mode (lin_mode),
      .low      (low_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         start_q <= '0;
      end else if (load) begin
         addr_q  <= addr_in;
         start_q <= addr_in[BW-1:0];
      end else if (step) begin
         addr_q[BW-1:0] <= low_nxt;
      end
   end

   assign addr_out = addr_q;

   // R9
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_n && !load) |=> $stable(addr_q));

   // R6
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(addr_q[AW-1:AW-UW]));

   // R11
   desel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chip_sel && !load) |=> ($stable(addr_q) && !burst_active));

   // R2
   ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_stb_n |=> (addr_q == $past(addr_in)));

endmodule

// File: tb/sim_bseq_addr_gen.sv
`timescale 1ns/100ps
module sim_bseq_addr_gen;

   localparam int AW = 8;
   localparam int BW = 2;
   localparam int NAUX = 2;
   localparam logic [1:0] AUX_POL = 2'b10;
   localparam logic [1:0] AUX_ON  = 2'b10;
   localparam logic [1:0] AUX_OFF = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1, lin_mode = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic ce_main_n = 1'b1;
   logic [NAUX-1:0] ce_aux = AUX_OFF;
   logic [AW-1:0] addr_out;
   logic burst_active, chip_sel, proc_started;

   int n_chk = 0, n_fail = 0;
   bit running = 1'b0;
   bit done = 1'b0;
   string cur_req = "R2";

   int m_addr = 0, m_start = 0, m_cnt = 0;
   bit m_act = 0, m_sel = 0, m_proc = 0;

   always #2.5 clk = ~clk;

   bseq_addr_gen #(.AW(AW), .BW(BW), .NAUX(NAUX), .AUX_ACT_HI(AUX_POL), .HAS_LINEAR(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
      .adv_n(adv_n), .lin_mode(lin_mode), .addr_in(addr_in), .ce_main_n(ce_main_n),
      .ce_aux(ce_aux), .addr_out(addr_out), .burst_active(burst_active),
      .chip_sel(chip_sel), .proc_started(proc_started)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_addr = 0; m_start = 0; m_cnt = 0; m_act = 0; m_sel = 0; m_proc = 0;
      end else begin
         bit pv, cv;
         pv = !proc_stb_n && !ce_main_n;
         cv = !ctrl_stb_n;
         if (pv || cv) begin
            m_addr  = int'(addr_in);
            m_start = m_addr % 4;
            m_cnt   = 0;
            m_sel   = !ce_main_n && !ce_aux[0] && ce_aux[1];
            m_act   = m_sel;
            m_proc  = pv;
         end else if (!adv_n && m_sel) begin
            int lo;
            m_cnt = (m_cnt + 1) % 4;
            lo = lin_mode ? (m_start + m_cnt) % 4 : (m_start ^ m_cnt);
            m_addr = (m_addr / 4) * 4 + lo;
            if (m_cnt == 0) m_act = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (running) begin
         check(cur_req, "addr_out", int'(addr_out), m_addr);
         check(cur_req, "burst_active", int'(burst_active), int'(m_act));
         check(cur_req, "chip_sel", int'(chip_sel), int'(m_sel));
         check(cur_req, "proc_started", int'(proc_started), int'(m_proc));
      end
   end

   task automatic cyc(input logic p_n, input logic c_n, input logic a_n, input logic [AW-1:0] a);
      proc_stb_n = p_n; ctrl_stb_n = c_n; adv_n = a_n; addr_in = a;
      @(negedge clk);
   endtask

   task automatic burst(input string req, input logic lm, input logic [AW-1:0] a, input bit use_proc, input int n_adv);
      cur_req = req;
      lin_mode = lm;
      ce_main_n = 1'b0; ce_aux = AUX_ON;
      if (use_proc) cyc(1'b0, 1'b1, 1'b1, a);
      else          cyc(1'b1, 1'b0, 1'b1, a);
      for (int i = 0; i < n_adv; i++) cyc(1'b1, 1'b1, 1'b0, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "addr_out", int'(addr_out), 0);
      check("R1", "burst_active", int'(burst_active), 0);
      check("R1", "chip_sel", int'(chip_sel), 0);
      check("R1", "proc_started", int'(proc_started), 0);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk);

      // R2 / R7 / R10: interleaved from start 2, wrap and keep cycling
      burst("R7", 1'b0, 8'h5A, 1'b0, 6);
      // explicit: after 6 advances from 2: cnt 2 -> low 2^2=0
      check("R10", "addr after wrap", int'(addr_out), 8'h58);
      check("R10", "active after wrap", int'(burst_active), 0);
      check("R4", "ctrl load source", int'(proc_started), 0);

      // R8: linear from start 1 via processor strobe
      burst("R8", 1'b1, 8'h31, 1'b1, 3);
      check("R8", "linear third beat", int'(addr_out), 8'h30);
      check("R4", "proc load source", int'(proc_started), 1);
      check("R8", "active mid burst", int'(burst_active), 1);

      // all starts in both modes, beyond wrap
      for (int s = 0; s < 4; s++) begin
         burst("R7", 1'b0, 8'hC4 + 8'(s), 1'b0, 5);
         burst("R8", 1'b1, 8'h94 + 8'(s), 1'b1, 5);
      end

      // R6: upper bits stay during a burst from all-ones upper field
      burst("R6", 1'b1, 8'hFF, 1'b0, 2);
      check("R6", "upper bits kept", int'(addr_out[AW-1:BW]), 8'hFF >> 2);

      // R9: wait states in the middle of a burst
      burst("R9", 1'b0, 8'h21, 1'b0, 1);
      cur_req = "R9";
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 8'hEE);
      check("R9", "held address", int'(addr_out), 8'h20);
      cyc(1'b1, 1'b1, 1'b0, 8'h00);
      check("R9", "resume after wait", int'(addr_out), 8'h23);

      // R3: processor strobe with main enable off is ignored
      cur_req = "R3";
      ce_main_n = 1'b1;
      cyc(1'b0, 1'b1, 1'b1, 8'h77);
      check("R3", "ignored proc load", int'(addr_out), 8'h23);
      check("R3", "proc_started kept", int'(proc_started), 0);
      check("R3", "chip_sel kept", int'(chip_sel), 1);

      // R4: both strobes valid -> processor source
      cur_req = "R4";
      ce_main_n = 1'b0;
      cyc(1'b0, 1'b0, 1'b1, 8'h42);
      check("R4", "both strobes source", int'(proc_started), 1);
      cyc(1'b1, 1'b0, 1'b1, 8'h43);
      check("R4", "ctrl only source", int'(proc_started), 0);

      // R5: load together with advance
      burst("R5", 1'b0, 8'h10, 1'b0, 2);
      cur_req = "R5";
      cyc(1'b1, 1'b0, 1'b0, 8'hAB);
      check("R5", "load beats advance", int'(addr_out), 8'hAB);
      cyc(1'b1, 1'b1, 1'b0, 8'h00);
      check("R5", "restart from new start", int'(addr_out), 8'hAA);

      // R11: deselect by auxiliary enable, then by main enable via ctrl strobe
      cur_req = "R11";
      ce_main_n = 1'b0; ce_aux = AUX_OFF;
      cyc(1'b1, 1'b0, 1'b1, 8'h66);
      check("R11", "chip_sel aux off", int'(chip_sel), 0);
      check("R11", "active aux off", int'(burst_active), 0);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 8'h00);
      check("R11", "advance ignored", int'(addr_out), 8'h66);
      ce_main_n = 1'b1; ce_aux = AUX_ON;
      cyc(1'b1, 1'b0, 1'b1, 8'h99);
      check("R11", "chip_sel main off", int'(chip_sel), 0);
      check("R2", "ctrl loads while deselected", int'(addr_out), 8'h99);
      ce_main_n = 1'b0; ce_aux = 2'b00;
      cyc(1'b1, 1'b0, 1'b1, 8'h55);
      check("R11", "chip_sel other aux off", int'(chip_sel), 0);
      ce_aux = AUX_ON;
      cyc(1'b1, 1'b0, 1'b1, 8'h55);
      check("R11", "chip_sel all on", int'(chip_sel), 1);
      check("R11", "active all on", int'(burst_active), 1);

      // R1: reset mid burst
      cyc(1'b1, 1'b1, 1'b0, 8'h00);
      running = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", "addr after reset", int'(addr_out), 0);
      check("R1", "chip_sel after reset", int'(chip_sel), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=hung exp=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule